// File: doc/BRIEF.md
# Pixel Clock PLL Reprogramming Sequencer

This block changes the settings of a pixel-clock PLL without glitching the clock tree. It does so by rewriting the PLL's 32-bit control register in a fixed order. A requester presents a new setting together with the register's present contents and pulses a request. The sequencer captures both values. It then issues five single-cycle register writes on its output port. Each write builds on the value of the one before.

The PLL is first forced into reset and bypass, with its power-down control bit cleared. The new setting is then merged in, with the control bits masked off. After a settling wait of about a millisecond, the PLL is enabled, then taken out of reset, and finally taken out of bypass. The analog PLL and the register itself lie outside the block. The register sees only the strobe and data that this block drives.

The settling wait is a cycle count. It is derived at elaboration time from the system clock frequency and the wanted wait in microseconds.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is asserted, and after reset until a request is taken, `wr_o`, `busy_o` and `done_o` are all 0.
- R2: A request sampled high while idle is accepted at that clock edge. In the following cycle `busy_o` is 1 and the first write strobe is present.
- R3: The first write carries the captured current value with bit 5 cleared and bits 31 and 8 set.
- R4: The second write follows in the next cycle. It carries the first write's value ORed with the captured new setting, where bits 31, 11, 8 and 5 of the setting are forced to 0 before the merge.
- R5: Between the second and third writes there are exactly SETTLE_CYC cycles with no strobe. SETTLE_CYC = (CLK_HZ / 1,000,000) × SETTLE_US.
- R6: The third write carries the second write's value with bit 11 set.
- R7: The fourth write follows in the next cycle. It carries the third write's value with bit 31 cleared.
- R8: The fifth write follows in the next cycle. It carries the fourth write's value with bit 8 cleared.
- R9: Every strobe lasts exactly one cycle, and each accepted request produces exactly five strobes.
- R10: `done_o` is 1 for exactly one cycle, the cycle after the fifth write. `busy_o` stays 1 from the first strobe through that cycle and is 0 in the next.
- R11: While `busy_o` is 1, the request input and any change on `setting_i` or `cur_i` have no effect. The writes, their timing and the single done pulse are unchanged.
- R12: A request raised in the first idle cycle after `done_o` is accepted, and it runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request to reprogram the PLL |
| setting_i | input | 32 | New PLL setting, captured on acceptance |
| cur_i | input | 32 | Present control register value, captured on acceptance |
| wr_o | output | 1 | Single-cycle register write strobe |
| wdata_o | output | 32 | Register write data, valid while `wr_o` is 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest case to reach from the ports is a request that lands while the sequence is in flight, with the captured inputs changing at the same time. A design that recaptures either input, or that restarts, would write different data or a different number of strobes. The disturbing scenario holds `req_i` high for the whole sequence and drives the bitwise complement of both inputs from the first strobe on. It then checks all five write values, their cycle positions and the single done pulse against the original inputs. A following scenario issues a request in the first idle cycle after done, to show that the sequencer re-arms without a dead cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int REG_W   = 32;
  localparam int BIT_RST = 31;
  localparam int BIT_EN  = 11;
  localparam int BIT_BYP = 8;
  localparam int BIT_PD  = 5;

  localparam logic [REG_W-1:0] M_RST = REG_W'(1) << BIT_RST;
  localparam logic [REG_W-1:0] M_EN  = REG_W'(1) << BIT_EN;
  localparam logic [REG_W-1:0] M_BYP = REG_W'(1) << BIT_BYP;
  localparam logic [REG_W-1:0] M_PD  = REG_W'(1) << BIT_PD;
  localparam logic [REG_W-1:0] M_CTL = M_RST | M_EN | M_BYP | M_PD;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_FORCE = 4'd1,
    ST_MERGE = 4'd2,
    ST_SETTLE= 4'd3,
    ST_ENA   = 4'd4,
    ST_UNRST = 4'd5,
    ST_UNBYP = 4'd6,
    ST_FIN   = 4'd7
  } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned WAIT_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CYC   = (WAIT_CYC < 1) ? 1 : WAIT_CYC;
  localparam int          CNT_W = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5
  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/pll_seq_image.sv
module pll_seq_image
  import pll_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [REG_W-1:0] setting_i,
  input  logic [REG_W-1:0] cur_i,
  input  seq_state_e       step_i,
  input  logic             wr_i,
  output logic [REG_W-1:0] wdata_o
);
  logic [REG_W-1:0] img_q, img_d, set_q;
  logic             img_en;

  always_comb begin
    unique case (step_i)
      ST_FORCE: img_d = (img_q & ~M_PD) | M_RST | M_BYP;
      ST_MERGE: img_d = img_q | (set_q & ~M_CTL);
      ST_ENA:   img_d = img_q | M_EN;
      ST_UNRST: img_d = img_q & ~M_RST;
      ST_UNBYP: img_d = img_q & ~M_BYP;
      default:  img_d = img_q;
    endcase
    img_en = cap_i || wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      img_q <= '0;
    else if (img_en) img_q <= cap_i ? cur_i : img_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     set_q <= '0;
    else if (cap_i) set_q <= setting_i;
  end

  assign wdata_o = img_d;

  AST_MERGE_KEEPS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_MERGE) |-> (wdata_o[BIT_RST] && wdata_o[BIT_BYP] && !wdata_o[BIT_PD])); // R4
  AST_ENA_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_ENA) |-> (wdata_o[BIT_EN] && wdata_o[BIT_RST] && wdata_o[BIT_BYP])); // R6
  AST_LAST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_UNBYP) |-> (!wdata_o[BIT_RST] && !wdata_o[BIT_BYP] && wdata_o[BIT_EN])); // R8

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       expired_i,
  output seq_state_e state_o,
  output logic       cap_o,
  output logic       wr_o,
  output logic       run_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = ST_FORCE;
      ST_FORCE:  st_d = ST_MERGE;
      ST_MERGE:  st_d = ST_SETTLE;
      ST_SETTLE: if (expired_i) st_d = ST_ENA;
      ST_ENA:    st_d = ST_UNRST;
      ST_UNRST:  st_d = ST_UNBYP;
      ST_UNBYP:  st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign cap_o   = (st_q == ST_IDLE) && req_i;
  assign wr_o    = (st_q == ST_FORCE) || (st_q == ST_MERGE) || (st_q == ST_ENA) ||
                   (st_q == ST_UNRST) || (st_q == ST_UNBYP);
  assign run_o   = (st_q == ST_SETTLE);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_FIN);

  AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> busy_o); // R9
  AST_ENA_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENA) |-> ($past(st_q) == ST_SETTLE)); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_o)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R10
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> (st_q != ST_FORCE)); // R11

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [REG_W-1:0] setting_i,
  input  logic [REG_W-1:0] cur_i,
  output logic             wr_o,
  output logic [REG_W-1:0] wdata_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

  seq_state_e step;
  logic       cap, run, expired, wr;

  pll_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .expired_i (expired),
    .state_o   (step),
    .cap_o     (cap),
    .wr_o      (wr),
    .run_o     (run),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  pll_seq_timer #(.WAIT_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .expired_o (expired)
  );

  pll_seq_image u_image (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap),
    .setting_i (setting_i),
    .cur_i     (cur_i),
    .step_i    (step),
    .wr_i      (wr),
    .wdata_o   (wdata_o)
  );

  assign wr_o = wr;

  AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(wr_o) && $past(wr_o, 2)) |=> !wr_o || !busy_o || ($past(wdata_o) != wdata_o)); // R9

endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
  localparam int unsigned CLK_HZ    = 50_000_000;
  localparam int unsigned SETTLE_US = 2;
  localparam int          S         = (CLK_HZ / 1_000_000) * SETTLE_US;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [31:0] setting_i, cur_i;
  logic        wr_o, busy_o, done_o;
  logic [31:0] wdata_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_reprog_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .setting_i(setting_i), .cur_i(cur_i),
    .wr_o(wr_o), .wdata_o(wdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one sequence starting at the current negedge; disturb holds req and flips inputs.
  task automatic run_seq(input logic [31:0] cur, input logic [31:0] set, input bit disturb);
    logic [31:0] wv[5];
    int          wc[5];
    int          nw = 0;
    int          dc = -1;
    int          busy1 = 0;
    logic [31:0] e1, e2, e3, e4, e5;
    req_i = 1'b1; cur_i = cur; setting_i = set;
    for (int cyc = 1; cyc <= S + 30 && dc < 0; cyc++) begin
      @(negedge clk);
      if (wr_o) begin
        if (nw < 5) begin wv[nw] = wdata_o; wc[nw] = cyc; end
        nw++;
      end
      if (cyc == 1) busy1 = busy_o;
      if (done_o) dc = cyc;
      if (disturb && dc < 0) begin
        req_i = 1'b1; cur_i = ~cur; setting_i = ~set;
      end else begin
        req_i = 1'b0;
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done width", done_o, 0);
    chk(busy_o == 1'b0, "R10 busy after done", busy_o, 0);
    e1 = (cur & ~32'h0000_0020) | 32'h8000_0100;
    e2 = e1 | (set & ~32'h8000_0920);
    e3 = e2 | 32'h0000_0800;
    e4 = e3 & ~32'h8000_0000;
    e5 = e4 & ~32'h0000_0100;
    chk(busy1 == 1, "R2 busy on first strobe", busy1, 1);
    chk(nw == 5, "R9 strobe count", nw, 5);
    if (nw >= 5) begin
      chk(wc[0] == 1, "R2 first strobe cycle", wc[0], 1);
      chk(wv[0] == e1, "R3 force write", wv[0], e1);
      chk(wc[1] == 2, "R4 merge cycle", wc[1], 2);
      chk(wv[1] == e2, "R4 merge write", wv[1], e2);
      chk(wc[2] == 3 + S, "R5 settle gap", wc[2], 3 + S);
      chk(wv[2] == e3, "R6 enable write", wv[2], e3);
      chk(wc[3] == 4 + S && wv[3] == e4, "R7 release reset", wv[3], e4);
      chk(wc[4] == 5 + S && wv[4] == e5, "R8 release bypass", wv[4], e5);
    end
    chk(dc == 6 + S, "R10 done cycle", dc, 6 + S);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_i = 1'b0; setting_i = '0; cur_i = '0;
    repeat (3) @(negedge clk);
    chk(!wr_o && !busy_o && !done_o, "R1 in reset", {wr_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_o && !busy_o && !done_o, "R1 idle after reset", {wr_o, busy_o, done_o}, 0);
  endtask

  task automatic t_patterns();
    run_seq(32'h0000_0000, 32'h0000_0000, 0);
    run_seq(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_seq(32'h33915801, 32'h2710C805, 0);
    run_seq(32'h0000_0820, 32'h5A5A_A5A5, 0);
  endtask

  task automatic t_busy_ignore();
    run_seq(32'h1234_0020, 32'h37E2_2801, 1); // R11
  endtask

  task automatic t_back_to_back();
    run_seq(32'hA5A5_5A5A, 32'h2308_8801, 0);
    run_seq(32'h0F0F_0F0F, 32'hF0F0_F0F0, 0); // R12
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_busy_ignore();
    t_back_to_back();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule